// File: doc/BRIEF.md
# Front-End Crossing Packet Formatter

This block turns one bunch crossing's worth of front-end output into a single packet word for a shared optical link. On every cycle that carries a crossing, it receives the crossing's status flags, its 12-bit crossing stamp, a payload length and a payload. These come from the compression stage, or raw data when compression is bypassed. It then emits a packet word made of a truncation bit, a crossing ID field, a length field and a payload.

Reserved length codes and the truncation bit tell the back end what kind of crossing it is looking at:
- an empty crossing;
- a compressed crossing;
- a raw (non-zero-suppressed) crossing;
- a synchronisation frame;
- a truncated crossing;
- an oversized (big) event.

A data-valid bit sits at the top of the packet word and is also brought out on its own pin. Several buffers can therefore share one link frame, each marking its own field.

The output is registered. Every packet appears one clock after the crossing is presented. A cycle without a crossing yields an all-zero word with the data-valid bit low.

Top module: `pkt_hdr_fmt`

## Requirements
- R1: While reset is asserted, `out_dv` is 0 and `out_word` is all zeros.
- R2: A cycle with `in_valid` low yields, one clock later, `out_dv` = 0 and an all-zero `out_word`.
- R3: The layout of `out_word`, from MSB down, is:
  - data-valid bit (equal to `out_dv`);
  - truncation bit T;
  - ID field (low ID_W bits of `in_bxid`);
  - length field (LEN_W bits);
  - payload (DATA_W bits).

  A normal crossing, with no flag set and a length that is neither 0 nor all-ones, gives one clock later: dv=1, T=0, the ID field, length = `in_len` and payload = `in_data`.
- R4: A normal crossing with `in_len` = 0 is sent as empty: T=0, length 0, payload zero.
- R5: A normal crossing with `in_len` all-ones has its length clamped to all-ones minus one, because all-ones is reserved. The payload is passed unchanged.
- R6: When `in_nzs` is set, the packet has T=0, length all-ones, and the raw `in_data` as payload.
- R7: When any of `in_hdr_only`, `in_veto` or `in_buf_full` is set, the packet is truncated: T=1, the ID field, length code 0, and a zero payload.
- R8: When `in_big` is set, the packet is truncated with T=1, the ID field, length code 1, and a zero payload.
- R9: When `in_sync` is set, the packet has:
  - T=0 and the ID field;
  - length = SYNC_LEN (default 8);
  - payload = the full 12-bit `in_bxid` in its top 12 bits, with the rest filled by the 4-bit pattern 4'b1110 repeated from the LSB.
- R10: Holding `in_sync` for consecutive cycles emits one sync packet per cycle. Each carries that cycle's stamp.
- R11: When several flags are set, priority runs from sync, to the three truncation flags, to big event, to raw mode, to normal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A crossing is presented this cycle |
| in_nzs | input | 1 | Payload is raw, uncompressed data |
| in_sync | input | 1 | Send a synchronisation frame |
| in_veto | input | 1 | Crossing vetoed, header only |
| in_hdr_only | input | 1 | Header-only run mode |
| in_buf_full | input | 1 | Buffer full, payload dropped |
| in_big | input | 1 | Event too large, payload dropped |
| in_bxid | input | 12 | Crossing stamp |
| in_len | input | LEN_W | Payload length from compression |
| in_data | input | DATA_W | Compressed or raw payload |
| out_word | output | 2+ID_W+LEN_W+DATA_W | Packet word, data-valid bit at MSB |
| out_dv | output | 1 | Data-valid for this cycle |

## Verification
The hardest cases to reach are the flag collisions. These are a sync request arriving during buffer-full, a big event while a truncation flag is up, and raw mode together with a big event. A single wrong priority branch only shows up in these cases. The stimulus drives each collision pair directly through the flag pins, with distinct stamps and payloads. This makes the chosen branch visible from the length code and the payload.

The stimulus also holds sync across consecutive cycles with a changing stamp, to prove that each cycle produces its own frame. It further drives a length of exactly all-ones on a normal crossing, to hit the reserved-code clamp.

// File: rtl/pkt_fmt_pkg.sv
package pkt_fmt_pkg;

   localparam int BX_STAMP_W = 12;

   typedef enum logic [2:0] {
      KIND_IDLE  = 3'd0,
      KIND_DATA  = 3'd1,
      KIND_EMPTY = 3'd2,
      KIND_RAW   = 3'd3,
      KIND_SYNC  = 3'd4,
      KIND_CUT   = 3'd5,
      KIND_BIG   = 3'd6
   } xkind_e;

   typedef struct packed {
      logic nzs;
      logic sync;
      logic veto;
      logic hdr_only;
      logic buf_full;
      logic big;
   } xflags_t;

endpackage

// File: rtl/xing_classify.sv
module xing_classify
   import pkt_fmt_pkg::*;
(
   input  logic    valid,
   input  xflags_t flags,
   input  logic    len_zero,
   output xkind_e  kind
);

   always_comb begin
      if (!valid)
         kind = KIND_IDLE;
      else if (flags.sync)
         kind = KIND_SYNC;
      else if (flags.hdr_only || flags.veto || flags.buf_full)
         kind = KIND_CUT;
      else if (flags.big)
         kind = KIND_BIG;
      else if (flags.nzs)
         kind = KIND_RAW;
      else if (len_zero)
         kind = KIND_EMPTY;
      else
         kind = KIND_DATA;
   end

endmodule

// File: rtl/sync_fill.sv
module sync_fill #(
   parameter int          DATA_W  = 64,
   parameter int          STAMP_W = 12,
   parameter int          PAT_W   = 4,
   parameter logic [PAT_W-1:0] PAT = 4'b1110
) (
   input  logic [STAMP_W-1:0] stamp,
   output logic [DATA_W-1:0]  payload
);

   localparam int FILL_W = DATA_W - STAMP_W;
   localparam int N_REP  = FILL_W / PAT_W;

   if (FILL_W <= 0) begin : g_bad_fill
      $error("sync_fill: DATA_W must exceed STAMP_W");
   end
   if ((FILL_W % PAT_W) != 0) begin : g_bad_rep
      $error("sync_fill: fill width must be a multiple of PAT_W");
   end

   logic [FILL_W-1:0] fill;

   for (genvar i = 0; i < N_REP; i++) begin : g_rep
      assign fill[i*PAT_W +: PAT_W] = PAT;
   end

   assign payload = {stamp, fill};

endmodule

// File: rtl/field_build.sv
module field_build
   import pkt_fmt_pkg::*;
#(
   parameter int ID_W     = 12,
   parameter int LEN_W    = 4,
   parameter int DATA_W   = 64,
   parameter int SYNC_LEN = 8
) (
   input  xkind_e                  kind,
   input  logic [BX_STAMP_W-1:0]   bxid,
   input  logic [LEN_W-1:0]        len,
   input  logic [DATA_W-1:0]       data,
   input  logic [DATA_W-1:0]       sync_payload,
   output logic                    dv,
   output logic                    trunc,
   output logic [ID_W-1:0]         id_f,
   output logic [LEN_W-1:0]        len_f,
   output logic [DATA_W-1:0]       pay_f
);

   localparam logic [LEN_W-1:0] LEN_ONES  = '1;
   localparam logic [LEN_W-1:0] LEN_CLAMP = LEN_ONES - 1'b1;
   localparam logic [LEN_W-1:0] LEN_SYNC  = LEN_W'(SYNC_LEN);
   localparam logic [LEN_W-1:0] LEN_BIG   = LEN_W'(1);

   logic [ID_W-1:0] id_slice;
   assign id_slice = bxid[ID_W-1:0];

   always_comb begin
      dv    = 1'b1;
      trunc = 1'b0;
      id_f  = id_slice;
      len_f = '0;
      pay_f = '0;
      unique case (kind)
         KIND_IDLE: begin
            dv   = 1'b0;
            id_f = '0;
         end
         KIND_SYNC: begin
            len_f = LEN_SYNC;
            pay_f = sync_payload;
         end
         KIND_CUT: begin
            trunc = 1'b1;
         end
         KIND_BIG: begin
            trunc = 1'b1;
            len_f = LEN_BIG;
         end
         KIND_RAW: begin
            len_f = LEN_ONES;
            pay_f = data;
         end
         KIND_EMPTY: begin
            len_f = '0;
         end
         default: begin
            len_f = (len == LEN_ONES) ? LEN_CLAMP : len;
            pay_f = data;
         end
      endcase
   end

endmodule

// File: rtl/pkt_hdr_fmt.sv
module pkt_hdr_fmt
   import pkt_fmt_pkg::*;
#(
   parameter int ID_W     = 12,
   parameter int LEN_W    = 4,
   parameter int DATA_W   = 64,
   parameter int SYNC_LEN = 8,
   parameter int PAT_W    = 4,
   parameter logic [PAT_W-1:0] SYNC_PAT = 4'b1110,
   localparam int PKT_W   = 2 + ID_W + LEN_W + DATA_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_nzs,
   input  logic                   in_sync,
   input  logic                   in_veto,
   input  logic                   in_hdr_only,
   input  logic                   in_buf_full,
   input  logic                   in_big,
   input  logic [BX_STAMP_W-1:0]  in_bxid,
   input  logic [LEN_W-1:0]       in_len,
   input  logic [DATA_W-1:0]      in_data,
   output logic [PKT_W-1:0]       out_word,
   output logic                   out_dv
);

   if (ID_W < 1 || ID_W > BX_STAMP_W) begin : g_bad_id
      $error("pkt_hdr_fmt: ID_W must lie in 1..12");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("pkt_hdr_fmt: LEN_W must be at least 2");
   end
   if (SYNC_LEN < 1 || SYNC_LEN >= (1 << LEN_W) - 1) begin : g_bad_sync
      $error("pkt_hdr_fmt: SYNC_LEN collides with a reserved length code");
   end

   xflags_t          flags;
   xkind_e           kind;
   logic [DATA_W-1:0] sync_pay;
   logic             n_dv, n_trunc;
   logic [ID_W-1:0]  n_id;
   logic [LEN_W-1:0] n_len;
   logic [DATA_W-1:0] n_pay;
   logic [PKT_W-1:0] word_q;

   assign flags = '{nzs: in_nzs, sync: in_sync, veto: in_veto,
                    hdr_only: in_hdr_only, buf_full: in_buf_full, big: in_big};

   xing_classify u_classify (
      .valid    (in_valid),
      .flags    (flags),
      .len_zero (in_len == '0),
      .kind     (kind)
   );

   sync_fill #(
      .DATA_W  (DATA_W),
      .STAMP_W (BX_STAMP_W),
      .PAT_W   (PAT_W),
      .PAT     (SYNC_PAT)
   ) u_sync_fill (
      .stamp   (in_bxid),
      .payload (sync_pay)
   );

   field_build #(
      .ID_W     (ID_W),
      .LEN_W    (LEN_W),
      .DATA_W   (DATA_W),
      .SYNC_LEN (SYNC_LEN)
   ) u_fields (
      .kind         (kind),
      .bxid         (in_bxid),
      .len          (in_len),
      .data         (in_data),
      .sync_payload (sync_pay),
      .dv           (n_dv),
      .trunc        (n_trunc),
      .id_f         (n_id),
      .len_f        (n_len),
      .pay_f        (n_pay)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else
         word_q <= {n_dv, n_trunc, n_id, n_len, n_pay};
   end

   assign out_word = word_q;
   assign out_dv   = word_q[PKT_W-1];

endmodule

// File: rtl/pkt_hdr_fmt_chk.sv
module pkt_hdr_fmt_chk #(
   parameter int ID_W     = 12,
   parameter int LEN_W    = 4,
   parameter int DATA_W   = 64,
   parameter int SYNC_LEN = 8,
   localparam int PKT_W   = 2 + ID_W + LEN_W + DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_nzs,
   input logic              in_sync,
   input logic              in_veto,
   input logic              in_hdr_only,
   input logic              in_buf_full,
   input logic              in_big,
   input logic [DATA_W-1:0] in_data,
   input logic [PKT_W-1:0]  out_word,
   input logic              out_dv
);

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   logic              o_t;
   logic [LEN_W-1:0]  o_len;
   logic [DATA_W-1:0] o_pay;
   logic              cut_in, raw_in;
   assign o_t    = out_word[PKT_W-2];
   assign o_len  = out_word[DATA_W +: LEN_W];
   assign o_pay  = out_word[DATA_W-1:0];
   assign cut_in = in_hdr_only | in_veto | in_buf_full;
   assign raw_in = in_valid & ~in_sync & ~cut_in & ~in_big & in_nzs;

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (out_dv == 1'b0 && out_word == '0);
      end
   end

   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && !$past(in_valid) |-> (out_word == '0 && !out_dv));

   p_dv_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (out_dv == $past(in_valid)));

   p_raw_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && $past(raw_in) |-> (!o_t && o_len == '1 && o_pay == $past(in_data)));

   p_trunc_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_dv && o_t |-> (o_pay == '0));

   p_sync_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && $past(in_valid && in_sync) |-> (!o_t && o_len == LEN_W'(SYNC_LEN)));

endmodule

bind pkt_hdr_fmt pkt_hdr_fmt_chk #(
   .ID_W     (ID_W),
   .LEN_W    (LEN_W),
   .DATA_W   (DATA_W),
   .SYNC_LEN (SYNC_LEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_nzs      (in_nzs),
   .in_sync     (in_sync),
   .in_veto     (in_veto),
   .in_hdr_only (in_hdr_only),
   .in_buf_full (in_buf_full),
   .in_big      (in_big),
   .in_data     (in_data),
   .out_word    (out_word),
   .out_dv      (out_dv)
);

// File: tb/pkt_hdr_fmt_bench.sv
module pkt_hdr_fmt_bench;

   localparam int ID_W   = 12;
   localparam int LEN_W  = 4;
   localparam int DATA_W = 64;
   localparam int PKT_W  = 2 + ID_W + LEN_W + DATA_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 0, in_nzs = 0, in_sync = 0, in_veto = 0;
   logic              in_hdr_only = 0, in_buf_full = 0, in_big = 0;
   logic [11:0]       in_bxid = '0;
   logic [LEN_W-1:0]  in_len = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic [PKT_W-1:0]  out_word;
   logic              out_dv;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   typedef struct {
      logic [PKT_W:0] word;
      string          tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   pkt_hdr_fmt u_pkt_hdr_fmt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nzs(in_nzs),
      .in_sync(in_sync), .in_veto(in_veto), .in_hdr_only(in_hdr_only),
      .in_buf_full(in_buf_full), .in_big(in_big), .in_bxid(in_bxid),
      .in_len(in_len), .in_data(in_data), .out_word(out_word), .out_dv(out_dv)
   );

   function automatic logic [PKT_W-1:0] pack(logic dv, logic t, logic [11:0] id,
                                              logic [LEN_W-1:0] l, logic [DATA_W-1:0] p);
      return {dv, t, id[ID_W-1:0], l, p};
   endfunction

   function automatic logic [DATA_W-1:0] sync_pay(logic [11:0] b);
      logic [DATA_W-1:0] p;
      p = '0;
      for (int i = 0; i < 13; i++) p[i*4 +: 4] = 4'b1110;
      p[DATA_W-1 -: 12] = b;
      return p;
   endfunction

   task automatic report(string tag, logic [PKT_W:0] act, logic [PKT_W:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // flags order: sync, hdr, veto, full, big, nzs
   task automatic drive(string tag, logic v, logic sy, logic ho, logic ve, logic bf,
                        logic bg, logic nz, logic [11:0] b, logic [LEN_W-1:0] l,
                        logic [DATA_W-1:0] d);
      exp_t e;
      logic [PKT_W-1:0] w;
      @(negedge clk);
      in_valid = v; in_sync = sy; in_hdr_only = ho; in_veto = ve;
      in_buf_full = bf; in_big = bg; in_nzs = nz; in_bxid = b; in_len = l; in_data = d;
      if (!v)                  w = '0;
      else if (sy)             w = pack(1, 0, b, LEN_W'(8), sync_pay(b));
      else if (ho || ve || bf) w = pack(1, 1, b, '0, '0);
      else if (bg)             w = pack(1, 1, b, LEN_W'(1), '0);
      else if (nz)             w = pack(1, 0, b, '1, d);
      else if (l == 0)         w = pack(1, 0, b, '0, '0);
      else if (l == '1)        w = pack(1, 0, b, LEN_W'(14), d);
      else                     w = pack(1, 0, b, l, d);
      e.word = {w[PKT_W-1], w};
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic finish_up();
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         report(e.tag, {out_dv, out_word}, e.word);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_up();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      report("R1 reset", {out_dv, out_word}, '0);
      rst_n = 1'b1;
      drive("R2 idle",        0,0,0,0,0,0,0, 12'h123, 4'd5, 64'hFFFF);
      drive("R3 normal a",    1,0,0,0,0,0,0, 12'hABC, 4'd5, 64'h0123456789ABCDEF);
      drive("R3 normal b",    1,0,0,0,0,0,0, 12'h001, 4'd1, 64'hDEADBEEF00000001);
      drive("R3 normal c",    1,0,0,0,0,0,0, 12'hFFF, 4'd14, 64'h8000000000000000);
      drive("R4 empty",       1,0,0,0,0,0,0, 12'h055, 4'd0, 64'h1111111111111111);
      drive("R5 clamp",       1,0,0,0,0,0,0, 12'h0F0, 4'hF, 64'h2222222222222222);
      drive("R6 raw",         1,0,0,0,0,0,1, 12'h777, 4'd3, 64'hCAFEF00DCAFEF00D);
      drive("R7 hdr only",    1,0,1,0,0,0,0, 12'h101, 4'd7, 64'h3333);
      drive("R7 veto",        1,0,0,1,0,0,0, 12'h202, 4'd7, 64'h4444);
      drive("R7 buf full",    1,0,0,0,1,0,0, 12'h303, 4'd7, 64'h5555);
      drive("R8 big",         1,0,0,0,0,1,0, 12'h404, 4'd9, 64'h6666);
      drive("R2 idle mid",    0,1,1,1,1,1,1, 12'hFFF, 4'hF, '1);
      drive("R9 sync",        1,1,0,0,0,0,0, 12'hC35, 4'd2, 64'h7777);
      drive("R10 sync hold1", 1,1,0,0,0,0,0, 12'hC36, 4'd2, 64'h7777);
      drive("R10 sync hold2", 1,1,0,0,0,0,0, 12'hC37, 4'd2, 64'h7777);
      drive("R11 sync>full",  1,1,0,0,1,0,0, 12'h0AA, 4'd6, 64'h8888);
      drive("R11 full>big",   1,0,0,0,1,1,0, 12'h0BB, 4'd6, 64'h9999);
      drive("R11 big>nzs",    1,0,0,0,0,1,1, 12'h0CC, 4'd6, 64'hAAAA);
      drive("R11 veto>nzs",   1,0,0,1,0,0,1, 12'h0DD, 4'd6, 64'hBBBB);
      drive("R11 nzs>empty",  1,0,0,0,0,0,1, 12'h0EE, 4'd0, 64'hCCCC);
      drive("R2 idle end",    0,0,0,0,0,0,0, 12'h000, 4'd0, '0);
      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule